// File: doc/BRIEF.md
# Double-Buffer DMA Ownership Controller

This block moves bytes between one serial channel direction and memory through two alternating buffers, A and B. Each buffer has its own base address, its own length and a single ownership flag. While the flag is clear the host may set up the buffer. Once the host sets the flag, the buffer belongs to the controller until it is finished. Because every buffer has exactly one owner at any time, neither side ever waits on the other for the same buffer.

A parameter selects the direction. In transmit mode the controller reads each owned buffer from memory one byte at a time and offers the bytes to the channel. In receive mode it writes bytes arriving from the channel into the owned buffer. In both modes a finished buffer is handed back to the host with a one-cycle completion pulse, and the controller then moves to the other buffer. When the next buffer is not handed over yet, transmit waits. Receive reports an overrun and discards the byte.

Top module: `dbuf_dma_ctrl`

## Requirements
- R1: After reset both ownership flags are 0, the active buffer is A (`activeBuf`=0), and `memReq`, `txValid`, `doneIrq` and `overrun` are low.
- R2: A host write with `regField`=2 sets the ownership flag of the buffer chosen by `regBuf` (0=A, 1=B). `ownBits` bit 0 shows A and bit 1 shows B, where 1 means the controller owns the buffer.
- R3: A host write with `regField`=0 (base address) or `regField`=1 (length) changes nothing while the addressed buffer is owned by the controller.
- R4: In transmit mode, an owned buffer with length N is read at addresses base..base+N-1 in ascending order. Each byte is held on `txData` with `txValid` high until a cycle with `txReady` high. Bytes are only offered from an owned buffer.
- R5: Each memory transfer moves one byte. `memReq` stays high with a stable `memAddr` and `memWe` until the cycle in which `memGnt` is high.
- R6: When the last byte of a buffer is transferred, `doneIrq` is high for that one cycle and `activeBuf` names the finished buffer. From the next cycle the ownership flag of that buffer is 0.
- R7: Processing starts at A and strictly alternates A, B, A, ... The active buffer changes only after a completion. In transmit mode nothing is requested while the active buffer is not owned, and transmission resumes when the buffer is handed over.
- R8: In receive mode, each byte taken from the channel is written with `memWe`=1 to base+count of the active buffer, in arrival order.
- R9: In receive mode, a byte that arrives while the active buffer is not owned, or while a memory write is still pending, raises `overrun` for that cycle. The byte is never written to memory.
- R10: An owned buffer with length 0 completes without any memory request.
- R11: Every buffer starts at offset 0 from its own base address, whatever the previous buffer's length was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Host register write strobe |
| regBuf | input | 1 | Buffer addressed by the write (0=A, 1=B) |
| regField | input | 2 | 0 base address, 1 length, 2 hand over (set ownership) |
| regData | input | 16 | Write data |
| ownBits | output | 2 | Ownership flags, bit 0 A, bit 1 B, 1 = controller |
| activeBuf | output | 1 | Buffer currently in use by the controller |
| doneIrq | output | 1 | One-cycle completion pulse for `activeBuf` |
| overrun | output | 1 | Receive byte dropped (receive mode) |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = write (receive), 0 = read (transmit) |
| memAddr | output | 16 | Transfer byte address |
| memWdata | output | 8 | Write data |
| memGnt | input | 1 | Grant; the transfer completes in this cycle |
| memRdata | input | 8 | Read data, valid with `memGnt` |
| txValid | output | 1 | Transmit byte available |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Channel accepts the transmit byte |
| rxValid | input | 1 | Received byte present for one cycle |
| rxData | input | 8 | Received byte |

## Verification
The assertions check on every cycle that memory requests and transmit bytes only ever come from an owned buffer, and that a pending request keeps its address and direction until granted. They also check that completion releases the finished buffer and flips the active one, and that the active buffer never moves without a completion. The bench scenarios are needed for what depends on data and ordering. These are the exact byte sequence and addresses, the A-then-B alternation across a stall, protection of the base and length registers, zero-length buffers, and which received bytes are written and which are dropped.

// File: rtl/dbuf_pkg.sv
`timescale 1ns/1ps
package dbuf_pkg;
  localparam int NBUF = 2;

  typedef enum logic [1:0] {
    FLD_ADDR = 2'd0,
    FLD_LEN  = 2'd1,
    FLD_GIVE = 2'd2,
    FLD_NONE = 2'd3
  } regField_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldByte;    // capture byte into holding register
    logic advance;   // one byte transferred, bump running count
    logic complete;  // release active buffer, switch to the other one
  } dmaStrobe_t;
endpackage

// File: rtl/dbuf_dp.sv
`timescale 1ns/1ps
module dbuf_dp
  import dbuf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 8,
  parameter int REG_W   = 16,
  parameter bit RX_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regBuf,
  input  logic [1:0]        regField,
  input  logic [REG_W-1:0]  regData,
  input  dmaStrobe_t        strb,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] rxData,
  output logic              ownCur,
  output logic              cntAtEnd,
  output logic              cntLast,
  output logic [NBUF-1:0]   ownBits,
  output logic              activeBuf,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] byteOut
);
  logic [ADDR_W-1:0] baseAddr [NBUF];
  logic [LEN_W-1:0]  bufLen   [NBUF];
  logic [NBUF-1:0]   own;
  logic [LEN_W-1:0]  count;
  logic              cur;
  logic [DATA_W-1:0] byteReg;
  regField_t         fld;

  assign fld = regField_t'(regField);

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic hostHit;
    assign hostHit = regWr && (regBuf == 1'(b)) && !own[b];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseAddr[b] <= '0;
        bufLen[b]   <= '0;
        own[b]      <= 1'b0;
      end else begin
        if (hostHit && fld == FLD_ADDR) baseAddr[b] <= regData[ADDR_W-1:0];
        if (hostHit && fld == FLD_LEN)  bufLen[b]   <= regData[LEN_W-1:0];
        if (regWr && regBuf == 1'(b) && fld == FLD_GIVE) own[b] <= 1'b1;
        // release by the controller wins over a same-cycle hand-over
        if (strb.complete && cur == 1'(b)) own[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      cur     <= 1'b0;
      byteReg <= '0;
    end else begin
      if (strb.ldByte) byteReg <= RX_MODE ? rxData : memRdata;
      if (strb.complete) begin
        count <= '0;
        cur   <= ~cur;
      end else if (strb.advance) begin
        count <= count + LEN_W'(1);
      end
    end
  end

  assign ownCur    = own[cur];
  assign cntAtEnd  = (count == bufLen[cur]);
  assign cntLast   = (LEN_W'(count + LEN_W'(1)) == bufLen[cur]);
  assign ownBits   = own;
  assign activeBuf = cur;
  assign memAddr   = baseAddr[cur] + ADDR_W'(count);
  assign byteOut   = byteReg;
endmodule

// File: rtl/dbuf_ctrl.sv
`timescale 1ns/1ps
module dbuf_ctrl
  import dbuf_pkg::*;
#(
  parameter bit RX_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ownCur,
  input  logic       cntAtEnd,
  input  logic       cntLast,
  input  logic       memGnt,
  input  logic       txReady,
  input  logic       rxValid,
  output dmaStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       overrun
);
  dmaState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  if (RX_MODE) begin : g_rx
    always_comb begin
      strb      = '0;
      nextState = state;
      memReq    = 1'b0;
      memWe     = 1'b0;
      txValid   = 1'b0;
      overrun   = 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ownCur && cntAtEnd) strb.complete = 1'b1;
          if (rxValid) begin
            if (ownCur && !cntAtEnd) begin
              strb.ldByte = 1'b1;
              nextState   = ST_BUSY;
            end else begin
              overrun = 1'b1;
            end
          end
        end
        ST_BUSY: begin
          memReq  = 1'b1;
          memWe   = 1'b1;
          overrun = rxValid;
          if (memGnt) begin
            strb.advance  = 1'b1;
            strb.complete = cntLast;
            nextState     = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end else begin : g_tx
    always_comb begin
      strb      = '0;
      nextState = state;
      memReq    = 1'b0;
      memWe     = 1'b0;
      txValid   = 1'b0;
      overrun   = 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ownCur) begin
            if (cntAtEnd) begin
              strb.complete = 1'b1;
            end else begin
              memReq = 1'b1;
              if (memGnt) begin
                strb.ldByte = 1'b1;
                nextState   = ST_BUSY;
              end
            end
          end
        end
        ST_BUSY: begin
          txValid = 1'b1;
          if (txReady) begin
            strb.advance  = 1'b1;
            strb.complete = cntLast;
            nextState     = ST_IDLE;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbuf_dma_ctrl.sv
`timescale 1ns/1ps
module dbuf_dma_ctrl
  import dbuf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 8,
  parameter bit RX_MODE = 1'b0,
  localparam int REG_W  = (ADDR_W > LEN_W) ? ADDR_W : LEN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regBuf,
  input  logic [1:0]        regField,
  input  logic [REG_W-1:0]  regData,
  output logic [NBUF-1:0]   ownBits,
  output logic              activeBuf,
  output logic              doneIrq,
  output logic              overrun,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic [DATA_W-1:0] memRdata,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData
);
  dmaStrobe_t        strb;
  logic              ownCur, cntAtEnd, cntLast;
  logic [DATA_W-1:0] byteOut;

  dbuf_ctrl #(.RX_MODE(RX_MODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .ownCur(ownCur), .cntAtEnd(cntAtEnd),
    .cntLast(cntLast), .memGnt(memGnt), .txReady(txReady), .rxValid(rxValid),
    .strb(strb), .memReq(memReq), .memWe(memWe), .txValid(txValid),
    .overrun(overrun)
  );

  dbuf_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .RX_MODE(RX_MODE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regBuf(regBuf),
    .regField(regField), .regData(regData), .strb(strb),
    .memRdata(memRdata), .rxData(rxData), .ownCur(ownCur),
    .cntAtEnd(cntAtEnd), .cntLast(cntLast), .ownBits(ownBits),
    .activeBuf(activeBuf), .memAddr(memAddr), .byteOut(byteOut)
  );

  assign doneIrq  = strb.complete;
  assign memWdata = byteOut;
  assign txData   = byteOut;
endmodule

// File: rtl/dbuf_dma_chk.sv
`timescale 1ns/1ps
module dbuf_dma_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memGnt,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              txValid,
  input logic              doneIrq,
  input logic              activeBuf,
  input logic [1:0]        ownBits
);
  AST_REQ_FROM_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ownBits[activeBuf]);                                   // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe)); // R5
  AST_TX_FROM_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ownBits[activeBuf]);                                  // R4
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !ownBits[$past(activeBuf)]);                          // R6
  AST_DONE_SWITCHES: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> activeBuf != $past(activeBuf));                       // R7
  AST_BUF_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !doneIrq |=> $stable(activeBuf));                                 // R7
endmodule

bind dbuf_dma_ctrl dbuf_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memGnt(memGnt), .memWe(memWe),
  .memAddr(memAddr), .txValid(txValid), .doneIrq(doneIrq),
  .activeBuf(activeBuf), .ownBits(ownBits)
);

// File: tb/dbuf_dma_ctrl_tb.sv
`timescale 1ns/1ps
module dbuf_dma_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // transmit instance signals
  logic t_regWr = 0, t_regBuf = 0; logic [1:0] t_regField = 0; logic [15:0] t_regData = 0;
  logic [1:0] t_own; logic t_act, t_irq, t_ovr, t_req, t_we, t_txValid;
  logic [15:0] t_addr; logic [7:0] t_wdata, t_txData;
  logic t_gnt = 0; logic [7:0] t_rdata = 0; logic t_txReady = 1;

  // receive instance signals
  logic r_regWr = 0, r_regBuf = 0; logic [1:0] r_regField = 0; logic [15:0] r_regData = 0;
  logic [1:0] r_own; logic r_act, r_irq, r_ovr, r_req, r_we, r_txValid;
  logic [15:0] r_addr; logic [7:0] r_wdata, r_txData;
  logic r_gnt = 0; logic r_rxValid = 0; logic [7:0] r_rxData = 0;

  dbuf_dma_ctrl #(.RX_MODE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(t_regWr), .regBuf(t_regBuf), .regField(t_regField),
    .regData(t_regData), .ownBits(t_own), .activeBuf(t_act), .doneIrq(t_irq),
    .overrun(t_ovr), .memReq(t_req), .memWe(t_we), .memAddr(t_addr),
    .memWdata(t_wdata), .memGnt(t_gnt), .memRdata(t_rdata), .txValid(t_txValid),
    .txData(t_txData), .txReady(t_txReady), .rxValid(1'b0), .rxData(8'h00)
  );

  dbuf_dma_ctrl #(.RX_MODE(1'b1)) dutRx_i (
    .clk(clk), .rstN(rstN), .regWr(r_regWr), .regBuf(r_regBuf), .regField(r_regField),
    .regData(r_regData), .ownBits(r_own), .activeBuf(r_act), .doneIrq(r_irq),
    .overrun(r_ovr), .memReq(r_req), .memWe(r_we), .memAddr(r_addr),
    .memWdata(r_wdata), .memGnt(r_gnt), .memRdata(8'h00), .txValid(r_txValid),
    .txData(r_txData), .txReady(1'b0), .rxValid(r_rxValid), .rxData(r_rxData)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // bench bookkeeping
  int gntDelay = 0;
  bit slowReady = 0;
  int tReqCnt = 0, tTxCnt = 0, tIrqCnt = 0;
  logic [7:0] tTxLog [64];
  logic tIrqLog [16];
  int rWrCnt = 0, rIrqCnt = 0, rOvrCnt = 0;
  logic [7:0] wmem [256];
  logic rIrqLog [16];
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // memory responders and channel drivers, all acting on the falling edge
  initial begin
    int tWait = 0, rWait = 0;
    for (int i = 0; i < 256; i++) wmem[i] = 8'hEE;
    forever begin
      @(negedge clk);
      cyc++;
      t_txReady = slowReady ? cyc[1] : 1'b1;
      if (t_gnt) t_gnt = 0;
      else if (t_req) begin
        if (tWait < gntDelay) tWait++;
        else begin t_gnt = 1; t_rdata = memByte(t_addr); tReqCnt++; tWait = 0; end
      end
      if (r_gnt) r_gnt = 0;
      else if (r_req) begin
        if (rWait < gntDelay) rWait++;
        else begin
          r_gnt = 1; rWait = 0;
          if (r_we) begin wmem[r_addr[7:0]] = r_wdata; rWrCnt++; end
        end
      end
    end
  end

  // monitor, 2 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk); #8;
      if (rstN) begin
        if (t_txValid && t_txReady) begin tTxLog[tTxCnt % 64] = t_txData; tTxCnt++; end
        if (t_irq) begin tIrqLog[tIrqCnt % 16] = t_act; tIrqCnt++; end
        if (r_irq) begin rIrqLog[rIrqCnt % 16] = r_act; rIrqCnt++; end
        if (r_ovr) rOvrCnt++;
      end
    end
  end

  task automatic hostWr(input bit rx, input bit b, input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    if (rx) begin r_regWr = 1; r_regBuf = b; r_regField = f; r_regData = d; end
    else    begin t_regWr = 1; t_regBuf = b; t_regField = f; t_regData = d; end
    @(negedge clk);
    r_regWr = 0; t_regWr = 0;
  endtask

  task automatic waitCnt(ref int cnt, input int target);
    for (int i = 0; i < 400 && cnt < target; i++) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge clk); r_rxValid = 1; r_rxData = b;
    @(negedge clk); r_rxValid = 0;
  endtask

  task automatic testReset;
    @(negedge clk); #8;
    chk(t_own == 2'b00 && r_own == 2'b00, "R1 own", {t_own, r_own}, 0);
    chk(t_act == 0 && r_act == 0, "R1 activeBuf", {t_act, r_act}, 0);
    chk(!t_req && !r_req && !t_txValid && !t_irq && !r_irq && !r_ovr, "R1 idle outputs",
        {t_req, r_req, t_txValid, t_irq, r_irq, r_ovr}, 0);
  endtask

  task automatic testTxBasic;
    hostWr(0, 0, 2'd0, 16'h0010);
    hostWr(0, 0, 2'd1, 16'd4);
    hostWr(0, 0, 2'd2, 16'h0000);
    #8; chk(t_own[0] == 1'b1, "R2 hand over sets own A", t_own, 1);
    hostWr(0, 0, 2'd0, 16'h0080);   // R3: ignored while owned
    waitCnt(tIrqCnt, 1);
    @(negedge clk); #8;
    chk(tTxCnt == 4, "R4 byte count", tTxCnt, 4);
    for (int i = 0; i < 4; i++)
      chk(tTxLog[i] == memByte(16'h0010 + 16'(i)), "R3 R4 byte order from base",
          tTxLog[i], memByte(16'h0010 + 16'(i)));
    chk(tIrqCnt == 1 && tIrqLog[0] == 1'b0, "R6 irq names A", tIrqLog[0], 0);
    chk(t_own[0] == 1'b0, "R6 own A released", t_own, 0);
    chk(t_act == 1'b1, "R7 switched to B", t_act, 1);
  endtask

  task automatic testTxStall;
    int req0, tx0;
    hostWr(0, 0, 2'd0, 16'h0020);
    hostWr(0, 0, 2'd1, 16'd2);
    hostWr(0, 0, 2'd2, 16'h0000);
    req0 = tReqCnt; tx0 = tTxCnt;
    repeat (20) @(negedge clk);
    #8;
    chk(tReqCnt == req0 && tTxCnt == tx0 && !t_req, "R7 stall on unowned B", tReqCnt - req0, 0);
    chk(t_act == 1'b1, "R7 stays on B while stalled", t_act, 1);
    hostWr(0, 1, 2'd0, 16'h0040);
    hostWr(0, 1, 2'd1, 16'd3);
    hostWr(0, 1, 2'd2, 16'h0000);
    waitCnt(tIrqCnt, 3);
    @(negedge clk); #8;
    chk(tTxCnt == tx0 + 5, "R7 five bytes after resume", tTxCnt - tx0, 5);
    for (int i = 0; i < 3; i++)
      chk(tTxLog[tx0 + i] == memByte(16'h0040 + 16'(i)), "R7 R11 B bytes first",
          tTxLog[tx0 + i], memByte(16'h0040 + 16'(i)));
    for (int i = 0; i < 2; i++)
      chk(tTxLog[tx0 + 3 + i] == memByte(16'h0020 + 16'(i)), "R11 A restarts at its base",
          tTxLog[tx0 + 3 + i], memByte(16'h0020 + 16'(i)));
    chk(tIrqLog[1] == 1'b1 && tIrqLog[2] == 1'b0, "R7 irq order B then A",
        {tIrqLog[1], tIrqLog[2]}, 2);
  endtask

  task automatic testTxZeroLen;
    int req0;
    req0 = tReqCnt;
    hostWr(0, 1, 2'd1, 16'd0);
    hostWr(0, 1, 2'd2, 16'h0000);
    waitCnt(tIrqCnt, 4);
    @(negedge clk); #8;
    chk(tIrqCnt == 4 && tIrqLog[3] == 1'b1, "R10 zero length completes B", tIrqCnt, 4);
    chk(tReqCnt == req0, "R10 no memory request", tReqCnt - req0, 0);
    chk(t_act == 1'b0 && t_own == 2'b00, "R10 back on A, released", {t_act, t_own}, 0);
  endtask

  task automatic testTxSlow;
    int tx0;
    tx0 = tTxCnt;
    gntDelay = 3; slowReady = 1;
    hostWr(0, 0, 2'd0, 16'h1230);
    hostWr(0, 0, 2'd1, 16'd3);
    hostWr(0, 0, 2'd2, 16'h0000);
    waitCnt(tIrqCnt, 5);
    @(negedge clk); #8;
    for (int i = 0; i < 3; i++)
      chk(tTxLog[tx0 + i] == memByte(16'h1230 + 16'(i)), "R5 slow grant bytes",
          tTxLog[tx0 + i], memByte(16'h1230 + 16'(i)));
    chk(tTxCnt == tx0 + 3, "R5 one byte per grant", tTxCnt - tx0, 3);
    gntDelay = 0; slowReady = 0;
  endtask

  task automatic testRxOverrunUnowned;
    sendRx(8'h11);
    repeat (3) @(negedge clk); #8;
    chk(rOvrCnt == 1, "R9 overrun on unowned A", rOvrCnt, 1);
    chk(rWrCnt == 0, "R9 dropped byte not written", rWrCnt, 0);
  endtask

  task automatic testRxFill;
    hostWr(1, 0, 2'd0, 16'h0030);
    hostWr(1, 0, 2'd1, 16'd3);
    hostWr(1, 0, 2'd2, 16'h0000);
    for (int i = 0; i < 3; i++) begin sendRx(8'hC1 + 8'(i)); repeat (4) @(negedge clk); end
    #8;
    for (int i = 0; i < 3; i++)
      chk(wmem[8'h30 + 8'(i)] == 8'hC1 + 8'(i), "R8 write to A", wmem[8'h30 + 8'(i)], 8'hC1 + 8'(i));
    chk(rIrqCnt == 1 && rIrqLog[0] == 1'b0, "R6 rx irq names A", rIrqCnt, 1);
    chk(r_own == 2'b00 && r_act == 1'b1, "R7 rx switched to B", {r_own, r_act}, 1);
    hostWr(1, 1, 2'd0, 16'h0050);
    hostWr(1, 1, 2'd1, 16'd2);
    hostWr(1, 1, 2'd2, 16'h0000);
    for (int i = 0; i < 2; i++) begin sendRx(8'hD1 + 8'(i)); repeat (4) @(negedge clk); end
    #8;
    chk(wmem[8'h50] == 8'hD1 && wmem[8'h51] == 8'hD2, "R8 R11 write to B from its base",
        {wmem[8'h50], wmem[8'h51]}, 16'hD1D2);
    chk(rIrqCnt == 2 && rIrqLog[1] == 1'b1, "R7 rx irq names B", rIrqCnt, 2);
  endtask

  task automatic testRxBusy;
    int w0, o0;
    gntDelay = 4;
    hostWr(1, 0, 2'd0, 16'h0060);
    hostWr(1, 0, 2'd1, 16'd2);
    hostWr(1, 0, 2'd2, 16'h0000);
    w0 = rWrCnt; o0 = rOvrCnt;
    @(negedge clk); r_rxValid = 1; r_rxData = 8'hE1;
    @(negedge clk); r_rxData = 8'hE2;
    @(negedge clk); r_rxValid = 0;
    repeat (10) @(negedge clk);
    sendRx(8'hE3);
    repeat (10) @(negedge clk); #8;
    chk(rOvrCnt == o0 + 1, "R9 overrun while write pending", rOvrCnt - o0, 1);
    chk(wmem[8'h60] == 8'hE1 && wmem[8'h61] == 8'hE3, "R9 busy byte dropped",
        {wmem[8'h60], wmem[8'h61]}, 16'hE1E3);
    chk(rWrCnt == w0 + 2, "R9 R5 two writes only", rWrCnt - w0, 2);
    chk(rIrqCnt == 3 && rIrqLog[2] == 1'b0, "R6 rx A completes again", rIrqCnt, 3);
    gntDelay = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTxBasic();
    testTxStall();
    testTxZeroLen();
    testTxSlow();
    testRxOverrunUnowned();
    testRxFill();
    testRxBusy();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule